// File: doc/BRIEF.md
# Warp Issue Scheduler with Register Scoreboard

This block sits between an instruction fetch stage and a shared execution unit in a multithreaded core. It keeps one pending instruction per warp (24 warps by default). An upstream fetch port deposits at most one warp instruction per cycle into the slot of the named warp. Every slot instruction carries an opcode, one destination register index, two source register indices and a 32-lane active mask.

Each warp has its own scoreboard with one pending bit per architectural register. A warp may issue only when its slot is full and none of the three registers named by its instruction is pending. Among the eligible warps, a rotating round-robin search starts just after the warp that issued last. The chosen instruction is broadcast with its lane mask to all 32 lanes. At the same time its destination register is marked pending and its slot is freed. A writeback port clears a pending bit once the result has been stored. The execution unit accepts a new instruction only every fourth cycle. Moving from one warp to another costs nothing extra.

Top module: `warpIssueSched`

## Requirements
- R1: While reset is held and after it is released with no fetch, issueValid and fetchStall stay low, and nothing issues until an instruction has been fetched.
- R2: A fetch aimed at a warp whose slot is full raises fetchStall in the same cycle. The offered instruction is dropped and the slot keeps its original instruction.
- R3: Two issueValid pulses are always at least 4 clock cycles apart, and issueValid is never high in two consecutive cycles.
- R4: A buffered instruction does not issue while its destination, first source or second source register is pending in its own warp's scoreboard.
- R5: Issuing marks the destination register pending in the issuing warp only. A writeback carrying (warp, register) clears that bit, and the waiting warp can then issue. A writeback of the same register index for a different warp leaves it blocked.
- R6: The round-robin search starts at the warp after the one that issued last and wraps from warp 23 to warp 0. After reset the search starts at warp 0.
- R7: When no warp is eligible in an issue slot, nothing issues.
- R8: An issue presents the warp index, opcode, destination, both sources and the 32-bit lane mask exactly as fetched, with issueValid high for one cycle. The slot is freed, so the next fetch to that warp is accepted without stall.
- R9: When several warps are eligible, they issue back to back exactly 4 cycles apart, with no extra cycles for changing warps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch port carries an instruction this cycle |
| fetchWarp | input | 5 | Target warp of the fetched instruction |
| fetchOp | input | 16 | Opcode |
| fetchDst | input | 4 | Destination register index |
| fetchSrcA | input | 4 | First source register index |
| fetchSrcB | input | 4 | Second source register index |
| fetchMask | input | 32 | Active lane mask |
| fetchStall | output | 1 | Fetch refused because the target slot is full |
| wbValid | input | 1 | Writeback of a result this cycle |
| wbWarp | input | 5 | Warp of the written-back register |
| wbReg | input | 4 | Register index written back |
| issueValid | output | 1 | An instruction is broadcast this cycle |
| issueWarp | output | 5 | Warp of the issued instruction |
| issueOp | output | 16 | Issued opcode |
| issueDst | output | 4 | Issued destination register |
| issueSrcA | output | 4 | Issued first source register |
| issueSrcB | output | 4 | Issued second source register |
| issueMask | output | 32 | Lane mask broadcast with the instruction |

## Verification
The bench makes warps wait on a pending source and on a pending destination. A scoreboard that ignores either field would let the instruction out early, which shows up as an unexpected issue. It sends a writeback to the right register of the wrong warp, which a design sharing one scoreboard would wrongly accept as a release. It also fills the slot of a blocked warp again: a missing stall would overwrite the slot and issue the wrong opcode. It makes several warps ready while a cooldown is running, including around the wrap from warp 23 to warp 0. A pointer that does not start after the last winner gives the wrong issue order, and a slow cooldown gives gaps longer than 4 cycles.

// File: rtl/warpSchedPkg.sv
package warpSchedPkg;
  localparam int WARPS     = 24;
  localparam int REGS      = 16;
  localparam int LANES     = 32;
  localparam int OP_W      = 16;
  localparam int ISSUE_GAP = 4;
  localparam int WID_W     = $clog2(WARPS);
  localparam int REG_W     = $clog2(REGS);
  localparam int COOL_W    = (ISSUE_GAP > 1) ? $clog2(ISSUE_GAP) : 1;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] srcA;
    logic [REG_W-1:0] srcB;
    logic [LANES-1:0] mask;
  } warpInstr_t;

  typedef struct packed {
    logic             issueEn;
    logic [WID_W-1:0] grantWarp;
  } schedStrobe_t;
endpackage

// File: rtl/warpSchedDp.sv
module warpSchedDp
  import warpSchedPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchValid,
  input  logic [WID_W-1:0]   fetchWarp,
  input  warpInstr_t         fetchInstr,
  output logic               fetchStall,
  input  logic               wbValid,
  input  logic [WID_W-1:0]   wbWarp,
  input  logic [REG_W-1:0]   wbReg,
  input  schedStrobe_t       strobe,
  output logic [WARPS-1:0]   eligible,
  output logic               issueValid,
  output logic [WID_W-1:0]   issueWarp,
  output warpInstr_t         issueInstr
);
  logic [WARPS-1:0]            slotValid;
  warpInstr_t                  slotInstr [WARPS];
  logic [WARPS-1:0][REGS-1:0]  pend;
  logic                        fetchInRange;
  logic                        fetchAccept;

  assign fetchInRange = int'(fetchWarp) < WARPS;
  assign fetchStall   = fetchValid && fetchInRange && slotValid[fetchWarp];
  assign fetchAccept  = fetchValid && fetchInRange && !slotValid[fetchWarp];

  for (genvar w = 0; w < WARPS; w++) begin : gSlot
    logic hitIssue;
    logic hitFetch;
    assign hitIssue = strobe.issueEn && (strobe.grantWarp == WID_W'(w));
    assign hitFetch = fetchAccept && (fetchWarp == WID_W'(w));

    always_ff @(posedge clk) begin
      if (!rstN)         slotValid[w] <= 1'b0;
      else if (hitIssue) slotValid[w] <= 1'b0;
      else if (hitFetch) slotValid[w] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hitFetch) slotInstr[w] <= fetchInstr;
    end

    for (genvar r = 0; r < REGS; r++) begin : gReg
      logic setBit;
      logic clrBit;
      assign setBit = hitIssue && (slotInstr[w].dst == REG_W'(r));
      assign clrBit = wbValid && (wbWarp == WID_W'(w)) && (wbReg == REG_W'(r));
      always_ff @(posedge clk) begin
        if (!rstN)       pend[w][r] <= 1'b0;
        else if (setBit) pend[w][r] <= 1'b1;
        else if (clrBit) pend[w][r] <= 1'b0;
      end
    end

    assign eligible[w] = slotValid[w]
                      && !pend[w][slotInstr[w].dst]
                      && !pend[w][slotInstr[w].srcA]
                      && !pend[w][slotInstr[w].srcB];
  end

  always_ff @(posedge clk) begin
    if (!rstN) issueValid <= 1'b0;
    else       issueValid <= strobe.issueEn;
  end

  always_ff @(posedge clk) begin
    if (strobe.issueEn) begin
      issueWarp  <= strobe.grantWarp;
      issueInstr <= slotInstr[strobe.grantWarp];
    end
  end
endmodule

// File: rtl/warpSchedCtl.sv
module warpSchedCtl
  import warpSchedPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [WARPS-1:0] eligible,
  output schedStrobe_t     strobe
);
  logic [COOL_W-1:0] cool;
  logic [WID_W-1:0]  lastWarp;
  logic              found;
  logic [WID_W-1:0]  pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 1; i <= WARPS; i++) begin
      int cand;
      cand = int'(lastWarp) + i;
      if (cand >= WARPS) cand = cand - WARPS;
      if (!found && eligible[WID_W'(cand)]) begin
        found = 1'b1;
        pick  = WID_W'(cand);
      end
    end
  end

  assign strobe.issueEn   = found && (cool == '0);
  assign strobe.grantWarp = pick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cool     <= '0;
      lastWarp <= WID_W'(WARPS - 1);
    end else if (strobe.issueEn) begin
      cool     <= COOL_W'(ISSUE_GAP - 1);
      lastWarp <= pick;
    end else if (cool != '0) begin
      cool <= cool - 1'b1;
    end
  end
endmodule

// File: rtl/warpIssueSched.sv
module warpIssueSched
  import warpSchedPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchValid,
  input  logic [WID_W-1:0] fetchWarp,
  input  logic [OP_W-1:0]  fetchOp,
  input  logic [REG_W-1:0] fetchDst,
  input  logic [REG_W-1:0] fetchSrcA,
  input  logic [REG_W-1:0] fetchSrcB,
  input  logic [LANES-1:0] fetchMask,
  output logic             fetchStall,
  input  logic             wbValid,
  input  logic [WID_W-1:0] wbWarp,
  input  logic [REG_W-1:0] wbReg,
  output logic             issueValid,
  output logic [WID_W-1:0] issueWarp,
  output logic [OP_W-1:0]  issueOp,
  output logic [REG_W-1:0] issueDst,
  output logic [REG_W-1:0] issueSrcA,
  output logic [REG_W-1:0] issueSrcB,
  output logic [LANES-1:0] issueMask
);
  warpInstr_t       fetchInstr;
  warpInstr_t       issueInstr;
  schedStrobe_t     strobe;
  logic [WARPS-1:0] eligible;

  assign fetchInstr = '{op: fetchOp, dst: fetchDst, srcA: fetchSrcA,
                        srcB: fetchSrcB, mask: fetchMask};

  warpSchedDp dp (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchWarp(fetchWarp), .fetchInstr(fetchInstr),
    .fetchStall(fetchStall),
    .wbValid(wbValid), .wbWarp(wbWarp), .wbReg(wbReg),
    .strobe(strobe), .eligible(eligible),
    .issueValid(issueValid), .issueWarp(issueWarp), .issueInstr(issueInstr)
  );

  warpSchedCtl ctl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .strobe(strobe)
  );

  assign issueOp   = issueInstr.op;
  assign issueDst  = issueInstr.dst;
  assign issueSrcA = issueInstr.srcA;
  assign issueSrcB = issueInstr.srcB;
  assign issueMask = issueInstr.mask;
endmodule

// File: rtl/warpSchedChk.sv
module warpSchedChk
  import warpSchedPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             fetchValid,
  input logic             fetchStall,
  input logic             issueValid,
  input logic [WID_W-1:0] issueWarp
);
  int sinceIssue;

  always_ff @(posedge clk) begin
    if (!rstN)                   sinceIssue <= ISSUE_GAP;
    else if (issueValid)         sinceIssue <= 1;
    else if (sinceIssue < 1000)  sinceIssue <= sinceIssue + 1;
  end

  // R3
  issue_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> sinceIssue >= ISSUE_GAP);

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> !issueValid);

  // R2
  stall_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchStall |-> fetchValid);

  // R8
  warp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> int'(issueWarp) < WARPS);
endmodule

bind warpIssueSched warpSchedChk chk (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchStall(fetchStall),
  .issueValid(issueValid), .issueWarp(issueWarp)
);

// File: tb/warpIssueSched_test.sv
module warpIssueSched_test;
  import warpSchedPkg::*;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             fetchValid = 1'b0;
  logic [WID_W-1:0] fetchWarp = '0;
  logic [OP_W-1:0]  fetchOp = '0;
  logic [REG_W-1:0] fetchDst = '0, fetchSrcA = '0, fetchSrcB = '0;
  logic [LANES-1:0] fetchMask = '0;
  logic             fetchStall;
  logic             wbValid = 1'b0;
  logic [WID_W-1:0] wbWarp = '0;
  logic [REG_W-1:0] wbReg = '0;
  logic             issueValid;
  logic [WID_W-1:0] issueWarp;
  logic [OP_W-1:0]  issueOp;
  logic [REG_W-1:0] issueDst, issueSrcA, issueSrcB;
  logic [LANES-1:0] issueMask;

  typedef struct {
    int          warp;
    int          op;
    int          dst;
    logic [31:0] mask;
    bit          tight;
  } expItem_t;

  expItem_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int lastIssue = -100;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  warpIssueSched uut (.*);

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pushExp(int w, int op, int dst, logic [31:0] m, bit tight);
    expItem_t it;
    it.warp = w; it.op = op; it.dst = dst; it.mask = m; it.tight = tight;
    expQ.push_back(it);
  endtask

  task automatic doFetch(int w, int op, int dst, int sa, int sb,
                         logic [31:0] m, bit expStall, string req);
    @(negedge clk);
    fetchValid = 1'b1; fetchWarp = WID_W'(w); fetchOp = OP_W'(op);
    fetchDst = REG_W'(dst); fetchSrcA = REG_W'(sa); fetchSrcB = REG_W'(sb);
    fetchMask = m;
    #1;
    check(fetchStall == expStall, req, "fetchStall", fetchStall, expStall);
    @(posedge clk); #1;
    fetchValid = 1'b0;
  endtask

  task automatic doWb(int w, int r);
    @(negedge clk);
    wbValid = 1'b1; wbWarp = WID_W'(w); wbReg = REG_W'(r);
    @(posedge clk); #1;
    wbValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(string req);
    check(expQ.size() == 0, req, "pending expected issues", expQ.size(), 0);
  endtask

  // monitor: pops expectations as issues appear
  always @(negedge clk) begin
    if (rstN && issueValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7/R4", "unexpected issue of warp", issueWarp, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(int'(issueWarp) == it.warp, "R6", "issueWarp", issueWarp, it.warp);
        check(int'(issueOp) == it.op, "R8", "issueOp", issueOp, it.op);
        check(int'(issueDst) == it.dst && issueMask == it.mask, "R8",
              "dst/mask", {issueDst, issueMask}, {it.dst[3:0], it.mask});
        check(cyc - lastIssue >= ISSUE_GAP, "R3", "issue gap", cyc - lastIssue, ISSUE_GAP);
        if (it.tight)
          check(cyc - lastIssue == ISSUE_GAP, "R9", "back-to-back gap",
                cyc - lastIssue, ISSUE_GAP);
      end
      lastIssue = cyc;
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check(issueValid == 1'b0, "R1", "issueValid in reset", issueValid, 0);
    check(fetchStall == 1'b0, "R1", "fetchStall in reset", fetchStall, 0);
    rstN = 1'b1;
    idle(10);
    check(issueValid == 1'b0, "R1", "issueValid idle", issueValid, 0);
    drained("R1");

    // R6/R9: warp 5 issues first, then 9 before 3 (search after 5)
    pushExp(5, 16'h0105, 1, 32'hFFFF_FFFF, 1'b0);
    pushExp(9, 16'h0109, 1, 32'h0000_00FF, 1'b1);
    pushExp(3, 16'h0103, 1, 32'h8000_0001, 1'b1);
    doFetch(5, 16'h0105, 1, 2, 3, 32'hFFFF_FFFF, 1'b0, "R8");
    doFetch(3, 16'h0103, 1, 2, 3, 32'h8000_0001, 1'b0, "R8");
    doFetch(9, 16'h0109, 1, 2, 3, 32'h0000_00FF, 1'b0, "R8");
    idle(15);
    drained("R6");

    // R8: slot of warp 5 freed after issue
    pushExp(5, 16'h0205, 4, 32'h1234_5678, 1'b0);
    doFetch(5, 16'h0205, 4, 6, 7, 32'h1234_5678, 1'b0, "R8");
    idle(10);
    drained("R8");

    // R4/R5/R2: source dependency on warp 7
    pushExp(7, 16'h0A07, 2, 32'h0000_FFFF, 1'b0);
    doFetch(7, 16'h0A07, 2, 0, 0, 32'h0000_FFFF, 1'b0, "R8");
    idle(8);
    drained("R5");
    doFetch(7, 16'h0B07, 9, 2, 3, 32'hFFFF_0000, 1'b0, "R4");
    doFetch(7, 16'h0C07, 11, 0, 0, 32'h0, 1'b1, "R2");
    idle(20);
    drained("R4");
    doWb(8, 2);          // wrong warp, must not release
    idle(10);
    drained("R5");
    pushExp(7, 16'h0B07, 9, 32'hFFFF_0000, 1'b0);
    doWb(7, 2);
    idle(10);
    drained("R5");

    // R4: destination dependency (r9 pending in warp 7)
    doFetch(7, 16'h0D07, 9, 0, 1, 32'h0F0F_0F0F, 1'b0, "R4");
    idle(15);
    drained("R7");
    pushExp(7, 16'h0D07, 9, 32'h0F0F_0F0F, 1'b0);
    doWb(7, 9);
    idle(10);
    drained("R4");

    // R6: wrap from warp 23 to warp 0
    pushExp(23, 16'h0117, 10, 32'h0000_0001, 1'b0);
    pushExp(0,  16'h0100, 10, 32'h0000_0002, 1'b1);
    pushExp(22, 16'h0116, 10, 32'h0000_0004, 1'b1);
    doFetch(23, 16'h0117, 10, 11, 12, 32'h0000_0001, 1'b0, "R6");
    doFetch(22, 16'h0116, 10, 11, 12, 32'h0000_0004, 1'b0, "R6");
    doFetch(0,  16'h0100, 10, 11, 12, 32'h0000_0002, 1'b0, "R6");
    idle(20);
    drained("R6");

    finishRun();
  end
endmodule